// File: doc/BRIEF.md
# Interrupt Entry and Context-Save Sequencer

This block steers a small processor core into and out of its interrupt routine. It has two request sources. One is an 8-bit free-running real-time counter whose wrap from FFh to 00h raises a pending flag; an enable bit gates that flag into a request. The other is a request level from an external port edge-detect unit. At an instruction boundary, with no handler running, the block takes the request of higher priority. In that cycle it forces the program counter to the vector address 000h, and at the clock edge it copies the core's context into a one-deep shadow stack.

The saved context is the program counter, status, file-select register, working register and mode register. While a handler is active, no further interrupt is taken. A return strobe presents the saved context back to the core and ends the handler. Instruction decode and the register file stay outside the block. The block sees them only through the context input and output buses.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the counter reads 00h, the counter-rollover enable bit is 0, the pending flag is 0 and `handler_active` is 0.
- R2: On each clock edge with `rtc_tick` high, the counter advances by one modulo 256, so FFh becomes 00h. With `rtc_tick` low, the counter holds its value.
- R3: The pending flag becomes 1 at the edge where the counter wraps from FFh to 00h. It then stays at 1 until an edge with `rtc_pend_clr` high and no wrap. A wrap and a clear at the same edge leave the flag at 1.
- R4: The pending flag requests an interrupt only while the enable bit is 1. The enable bit is written through `rtc_ie_we` and `rtc_ie_wdata`. With the enable at 0, a pending flag never produces `irq_take`.
- R5: `irq_take` is high in a cycle only when `boundary` is high, no handler is active, and some request is present. In that cycle `pc_load` is high and `pc_load_val` is 0. At the next edge `handler_active` becomes 1.
- R6: When both requests are present in the take cycle, the counter request wins and `irq_src` is 0. When only the external request is present, `irq_src` is 1.
- R7: At the take edge, the context inputs (PC, status, file-select, working, mode) are stored. The `sav_*` outputs keep those values until the next take, whatever the context inputs do in the meantime.
- R8: While `handler_active` is 1, no take happens. `reti` with a handler active raises `restore` and `pc_load`, puts the saved PC on `pc_load_val`, and clears `handler_active` at the next edge. `reti` with no handler active is ignored: `restore` and `pc_load` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_tick | input | 1 | Counter increment strobe |
| rtc_ie_we | input | 1 | Write strobe for the rollover enable bit |
| rtc_ie_wdata | input | 1 | Value written to the enable bit |
| rtc_pend_clr | input | 1 | Software clear of the rollover pending flag |
| ext_req | input | 1 | External edge interrupt request level |
| boundary | input | 1 | Instruction boundary valid |
| reti | input | 1 | Return-from-interrupt strobe |
| ctx_pc | input | PC_W | Live program counter |
| ctx_status | input | 8 | Live status register |
| ctx_fsr | input | 8 | Live file-select register |
| ctx_w | input | 8 | Live working register |
| ctx_mode | input | MODE_W | Live mode register |
| rtc_count | output | CNT_W | Real-time counter value |
| rtc_ie | output | 1 | Rollover enable bit |
| rtc_pending | output | 1 | Rollover pending flag |
| irq_take | output | 1 | Interrupt entry this cycle |
| irq_src | output | 1 | Source taken: 0 counter, 1 external |
| handler_active | output | 1 | Handler running, stack occupied |
| restore | output | 1 | Context restore this cycle |
| pc_load | output | 1 | Force the PC this cycle |
| pc_load_val | output | PC_W | Value forced onto the PC |
| sav_pc | output | PC_W | Saved program counter |
| sav_status | output | 8 | Saved status |
| sav_fsr | output | 8 | Saved file-select |
| sav_w | output | 8 | Saved working register |
| sav_mode | output | MODE_W | Saved mode register |

## Verification
The bench walks the counter through complete cycles of 256 ticks. A counter that saturates at FFh, or that sets the flag one edge early or late, shows up as a wrong count or a wrong flag at the wrap. A wrap is made to coincide with a software clear; a design that lets the clear win would lose that interrupt. Both sources are raised together at one boundary, and the bench retries entry while a handler is active. A wrong priority, or a second entry that overwrites the single-level stack, would return the wrong source or corrupt the saved context. Return strobes with no active handler check that a stray `reti` does not load the PC with stale context.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic {
    SRC_RTC = 1'b0,
    SRC_EXT = 1'b1
  } irq_src_e;

  // fixed priority: counter rollover ahead of the external port request
  function automatic irq_src_e pick_src(input logic rtc_req, input logic ext_req);
    if (rtc_req)      return SRC_RTC;
    else if (ext_req) return SRC_EXT;
    else              return SRC_RTC;
  endfunction

endpackage

// File: rtl/irq_rtc_timer.sv
module irq_rtc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ie_we,
  input  logic             ie_wdata,
  input  logic             pend_clr,
  output logic [CNT_W-1:0] count,
  output logic             ie,
  output logic             pending,
  output logic             req
);

  // returns {wrap, next}
  function automatic logic [CNT_W:0] rtc_step(input logic [CNT_W-1:0] c, input logic t);
    logic [CNT_W:0] sum;
    sum = {1'b0, c} + {{CNT_W{1'b0}}, t};
    return sum;
  endfunction

  logic [CNT_W:0] step_w;
  logic           rollover;

  assign step_w   = rtc_step(count, tick);
  assign rollover = step_w[CNT_W];
  assign req      = pending & ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      ie      <= 1'b0;
      pending <= 1'b0;
    end else begin
      count <= step_w[CNT_W-1:0];
      if (ie_we) ie <= ie_wdata;
      if (rollover)      pending <= 1'b1;
      else if (pend_clr) pending <= 1'b0;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + 1'b1);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  p_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> pending);
  p_pend_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !pend_clr) |=> pending);
  p_req_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ie);

endmodule

// File: rtl/irq_take_ctrl.sv
module irq_take_ctrl
  import irq_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     boundary,
  input  logic     rtc_req,
  input  logic     ext_req,
  input  logic     reti,
  output logic     take,
  output irq_src_e src,
  output logic     restore,
  output logic     active
);

  logic any_req;

  assign any_req = rtc_req | ext_req;
  assign take    = boundary & ~active & any_req;
  assign src     = pick_src(rtc_req, ext_req);
  assign restore = reti & active;

  always_ff @(posedge clk) begin
    if (!rst_n)       active <= 1'b0;
    else if (take)    active <= 1'b1;
    else if (restore) active <= 1'b0;
  end

  p_take_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> boundary && any_req);
  p_take_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> active);
  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rtc_req) |-> src == SRC_RTC);
  p_no_reenter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !take);
  p_reti_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> !active);

endmodule

// File: rtl/irq_shadow_stack.sv
module irq_shadow_stack #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         save,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (save) q <= d;
  end

  p_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> q == $past(d));
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !save |=> $stable(q));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PC_W   = 11,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_tick,
  input  logic              rtc_ie_we,
  input  logic              rtc_ie_wdata,
  input  logic              rtc_pend_clr,
  input  logic              ext_req,
  input  logic              boundary,
  input  logic              reti,
  input  logic [PC_W-1:0]   ctx_pc,
  input  logic [7:0]        ctx_status,
  input  logic [7:0]        ctx_fsr,
  input  logic [7:0]        ctx_w,
  input  logic [MODE_W-1:0] ctx_mode,
  output logic [CNT_W-1:0]  rtc_count,
  output logic              rtc_ie,
  output logic              rtc_pending,
  output logic              irq_take,
  output logic              irq_src,
  output logic              handler_active,
  output logic              restore,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_load_val,
  output logic [PC_W-1:0]   sav_pc,
  output logic [7:0]        sav_status,
  output logic [7:0]        sav_fsr,
  output logic [7:0]        sav_w,
  output logic [MODE_W-1:0] sav_mode
);

  localparam int CTX_W = PC_W + 24 + MODE_W;
  localparam logic [PC_W-1:0] VECTOR = '0;

  logic     rtc_req;
  irq_src_e src_e;
  logic [CTX_W-1:0] ctx_in, ctx_q;

  irq_rtc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(rtc_tick),
    .ie_we(rtc_ie_we), .ie_wdata(rtc_ie_wdata), .pend_clr(rtc_pend_clr),
    .count(rtc_count), .ie(rtc_ie), .pending(rtc_pending), .req(rtc_req)
  );

  irq_take_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .rtc_req(rtc_req), .ext_req(ext_req), .reti(reti),
    .take(irq_take), .src(src_e), .restore(restore), .active(handler_active)
  );

  assign ctx_in = {ctx_pc, ctx_status, ctx_fsr, ctx_w, ctx_mode};

  irq_shadow_stack #(.W(CTX_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .save(irq_take), .d(ctx_in), .q(ctx_q)
  );

  assign {sav_pc, sav_status, sav_fsr, sav_w, sav_mode} = ctx_q;

  assign irq_src     = src_e;
  assign pc_load     = irq_take | restore;
  assign pc_load_val = irq_take ? VECTOR : sav_pc;

  p_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> pc_load && pc_load_val == '0);
  p_stray_reti_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !handler_active && !irq_take) |-> !pc_load);
  p_one_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);

endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

  localparam int PC_W = 11;
  localparam int MODE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rtc_tick = 0, rtc_ie_we = 0, rtc_ie_wdata = 0, rtc_pend_clr = 0;
  logic ext_req = 0, boundary = 0, reti = 0;
  logic [PC_W-1:0] ctx_pc = '0;
  logic [7:0] ctx_status = '0, ctx_fsr = '0, ctx_w = '0;
  logic [MODE_W-1:0] ctx_mode = '0;
  logic [7:0] rtc_count;
  logic rtc_ie, rtc_pending, irq_take, irq_src, handler_active, restore, pc_load;
  logic [PC_W-1:0] pc_load_val, sav_pc;
  logic [7:0] sav_status, sav_fsr, sav_w;
  logic [MODE_W-1:0] sav_mode;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .rtc_ie_we(rtc_ie_we),
    .rtc_ie_wdata(rtc_ie_wdata), .rtc_pend_clr(rtc_pend_clr), .ext_req(ext_req),
    .boundary(boundary), .reti(reti), .ctx_pc(ctx_pc), .ctx_status(ctx_status),
    .ctx_fsr(ctx_fsr), .ctx_w(ctx_w), .ctx_mode(ctx_mode), .rtc_count(rtc_count),
    .rtc_ie(rtc_ie), .rtc_pending(rtc_pending), .irq_take(irq_take),
    .irq_src(irq_src), .handler_active(handler_active), .restore(restore),
    .pc_load(pc_load), .pc_load_val(pc_load_val), .sav_pc(sav_pc),
    .sav_status(sav_status), .sav_fsr(sav_fsr), .sav_w(sav_w), .sav_mode(sav_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic set_ctx(input int k);
    ctx_pc     = PC_W'((k * 123 + 7) % 2048);
    ctx_status = 8'((k * 37 + 1) % 256);
    ctx_fsr    = 8'((k * 53 + 9) % 256);
    ctx_w      = 8'((k * 71 + 200) % 256);
    ctx_mode   = 8'((k * 19 + 3) % 256);
  endtask

  task automatic chk_saved(input string req, input int k);
    chk(req, 32'(sav_pc), (k * 123 + 7) % 2048);
    chk(req, 32'(sav_status), (k * 37 + 1) % 256);
    chk(req, 32'(sav_fsr), (k * 53 + 9) % 256);
    chk(req, 32'(sav_w), (k * 71 + 200) % 256);
    chk(req, 32'(sav_mode), (k * 19 + 3) % 256);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int model;
    logic pend_m;
    repeat (3) cyc();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", 32'(rtc_count), 0);
    chk("R1", 32'(rtc_ie), 0);
    chk("R1", 32'(rtc_pending), 0);
    chk("R1", 32'(handler_active), 0);

    // R2 full sweep, R3 flag at wrap, R4 no take while disabled
    model = 0;
    pend_m = 0;
    rtc_tick = 1;
    boundary = 1;
    for (int i = 0; i < 256; i++) begin
      if (model == 255) pend_m = 1;
      cyc();
      model = (model + 1) % 256;
      chk("R2", 32'(rtc_count), 32'(model));
      chk("R3", 32'(rtc_pending), 32'(pend_m));
      chk("R4", 32'(irq_take), 0);
    end
    rtc_tick = 0;
    cyc();
    chk("R2 hold", 32'(rtc_count), 0);
    chk("R3 sticky", 32'(rtc_pending), 1);
    rtc_pend_clr = 1;
    cyc();
    rtc_pend_clr = 0;
    chk("R3 clear", 32'(rtc_pending), 0);

    // R3 wrap and clear at the same edge: flag set
    rtc_tick = 1;
    repeat (255) cyc();
    chk("R2", 32'(rtc_count), 255);
    rtc_pend_clr = 1;
    cyc();
    rtc_pend_clr = 0;
    rtc_tick = 0;
    chk("R2 wrap", 32'(rtc_count), 0);
    chk("R3 set wins", 32'(rtc_pending), 1);
    chk("R4 disabled", 32'(irq_take), 0);

    // enable the rollover interrupt
    boundary = 0;
    rtc_ie_we = 1;
    rtc_ie_wdata = 1;
    cyc();
    rtc_ie_we = 0;
    chk("R4 ie", 32'(rtc_ie), 1);
    chk("R5 no boundary", 32'(irq_take), 0);

    // R5/R6 both sources at one boundary
    set_ctx(100);
    ext_req = 1;
    boundary = 1;
    #1;
    chk("R5 take", 32'(irq_take), 1);
    chk("R5 pc_load", 32'(pc_load), 1);
    chk("R5 vector", 32'(pc_load_val), 0);
    chk("R6 prio", 32'(irq_src), 0);
    cyc();
    chk("R5 active", 32'(handler_active), 1);
    chk_saved("R7", 100);

    // R8 no re-entry while active; R7 stack unchanged
    set_ctx(101);
    #1;
    chk("R8 no take", 32'(irq_take), 0);
    cyc();
    chk_saved("R7 keep", 100);

    // R8 return
    reti = 1;
    #1;
    chk("R8 restore", 32'(restore), 1);
    chk("R8 pc_load", 32'(pc_load), 1);
    chk("R8 pc", 32'(pc_load_val), (100 * 123 + 7) % 2048);
    chk("R8 no take", 32'(irq_take), 0);
    boundary = 0;
    ext_req = 0;
    cyc();
    reti = 0;
    chk("R8 cleared", 32'(handler_active), 0);

    // R8 stray return
    reti = 1;
    #1;
    chk("R8 stray", 32'(restore), 0);
    chk("R8 stray", 32'(pc_load), 0);
    cyc();
    reti = 0;
    chk("R8 stray", 32'(handler_active), 0);

    // R6 external only, many context patterns
    rtc_pend_clr = 1;
    cyc();
    rtc_pend_clr = 0;
    for (int k = 0; k < 16; k++) begin
      set_ctx(k);
      boundary = 1;
      ext_req = 1;
      #1;
      chk("R6 ext", 32'(irq_take), 1);
      chk("R6 src", 32'(irq_src), 1);
      cyc();
      boundary = 0;
      ext_req = 0;
      set_ctx(k + 500);
      #1;
      chk_saved("R7", k);
      reti = 1;
      #1;
      chk("R8 pc", 32'(pc_load_val), 32'((k * 123 + 7) % 2048));
      cyc();
      reti = 0;
      chk("R8 cleared", 32'(handler_active), 0);
    end

    // R1 reset again after activity
    boundary = 1;
    ext_req = 1;
    cyc();
    rst_n = 0;
    boundary = 0;
    ext_req = 0;
    cyc();
    rst_n = 1;
    chk("R1", 32'(handler_active), 0);
    chk("R1", 32'(rtc_ie), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule